// File: doc/BRIEF.md
# Interrupt Destination Bitmask Resolver

This block turns one interrupt request into the set of local agents that must receive it. A request arrives either as a command (a destination byte, a physical/logical bit, a two-bit shorthand, a delivery mode, a vector and the trigger and level bits) or as a message-signalled address/data pair. For a message-signalled request, the block pulls those fields out of the two words itself.

Every agent supplies its ID byte, its logical-destination byte and a four-bit destination-model nibble. The resolver compares the request against all agents in parallel. It then applies the shorthand, narrows the set to one agent for lowest-priority delivery, and blanks the set when the delivery mode is undefined.

An INIT de-assert command delivers no interrupt. Instead it marks, in a separate mask, the agents that must copy their ID into their arbitration ID. The result is registered and appears one cycle after the request strobe.

Top module: `irq_dest_resolver`

## Requirements
- R1: In physical mode (logical bit 0) with shorthand 0, destination 0xFF selects every agent.
- R2: In physical mode, any other destination selects only the lowest-numbered agent whose ID equals it, and selects no agent if none matches.
- R3: In logical mode, an agent whose model nibble is 0xF is selected when the destination ANDed with its logical byte is nonzero.
- R4: In logical mode, an agent whose model nibble is 0x0 is selected when the upper nibbles of the destination and its logical byte are equal and their lower nibbles share a set bit. An agent with any other model nibble is never selected in logical mode.
- R5: For a command, shorthand 1 selects only the agent at `self_idx`, 2 selects all agents, and 3 selects all agents except `self_idx`. For shorthands 1 to 3 the destination byte and the mode bit have no effect.
- R6: Delivery mode 1 (lowest priority) reduces the selected set to its lowest-numbered agent.
- R7: Delivery modes 0, 2, 4, 5, 6 and 7 pass the selected set through unchanged. Mode 3 gives an empty delivery mask. The delivery mode, vector and trigger are output unchanged.
- R8: A command with delivery mode 5, level bit 0 and trigger bit 1 gives an empty delivery mask, and puts the selected set on `arb_load_mask` instead. In every other case `arb_load_mask` is 0.
- R9: For a message-signalled request, the destination is address bits 19:12, the mode bit is address bit 2, the vector is data bits 7:0, the delivery mode is data bits 10:8, and the trigger is data bit 15. The shorthand input is ignored, and the request is never treated as a de-assert.
- R10: After reset, `out_valid` and all masks are 0. The outputs update in the cycle after a `req_valid` cycle, and they hold their value otherwise. `out_valid` is 1 exactly in the cycle after each `req_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_is_msi | input | 1 | 1: decode msi_addr/msi_data; 0: use command fields |
| cmd_dest | input | 8 | Command destination byte |
| cmd_logical | input | 1 | Command mode bit, 1 = logical |
| cmd_shorthand | input | 2 | Command shorthand code |
| cmd_dmode | input | 3 | Command delivery mode |
| cmd_vector | input | 8 | Command vector |
| cmd_trig | input | 1 | Command trigger bit, 1 = level |
| cmd_level | input | 1 | Command level bit |
| self_idx | input | IDX_W | Index of the issuing agent |
| msi_addr | input | 20 | Message address, low 20 bits |
| msi_data | input | 16 | Message data, low 16 bits |
| agent_id | input | 8*N_AGENTS | Agent IDs, agent k in bits 8k+7:8k |
| agent_ldest | input | 8*N_AGENTS | Agent logical bytes, same packing |
| agent_model | input | 4*N_AGENTS | Agent model nibbles, agent k in bits 4k+3:4k |
| out_valid | output | 1 | Result strobe |
| out_mask | output | N_AGENTS | Delivery target mask |
| arb_load_mask | output | N_AGENTS | Agents that load their arbitration ID |
| out_dmode | output | 3 | Delivery mode |
| out_vector | output | 8 | Vector |
| out_trig | output | 1 | Trigger |

## Verification
The agent table mixes flat agents, cluster agents from two clusters, and one agent with an unsupported model. It also holds two agents that share an ID, so the physical match has to pick one of them. Logical destinations are chosen so that flat and cluster matches land in the same request. This separates the two rules from each other and from the exclusion of the odd model. Each shorthand is tried with a destination that would select a different set if it were not ignored. The same destinations are sent again as message words, which exposes any wrong field position.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int DEST_W  = 8;
  localparam int MODEL_W = 4;
  localparam int DM_W    = 3;

  localparam logic [DM_W-1:0] DM_FIXED  = 3'd0;
  localparam logic [DM_W-1:0] DM_LOWPRI = 3'd1;
  localparam logic [DM_W-1:0] DM_INIT   = 3'd5;

  localparam logic [MODEL_W-1:0] MODEL_FLAT    = 4'hF;
  localparam logic [MODEL_W-1:0] MODEL_CLUSTER = 4'h0;
  localparam logic [DEST_W-1:0]  DEST_ALL      = 8'hFF;

  typedef enum logic [1:0] {
    SH_NONE     = 2'd0,
    SH_SELF     = 2'd1,
    SH_ALL      = 2'd2,
    SH_OTHERS   = 2'd3
  } shorthand_e;

  function automatic logic flat_hit(input logic [DEST_W-1:0] dest,
                                    input logic [DEST_W-1:0] ldest);
    return (dest & ldest) != '0;
  endfunction

  function automatic logic cluster_hit(input logic [DEST_W-1:0] dest,
                                       input logic [DEST_W-1:0] ldest);
    return (dest[7:4] == ldest[7:4]) && ((dest[3:0] & ldest[3:0]) != 4'h0);
  endfunction

  function automatic logic logical_hit(input logic [DEST_W-1:0] dest,
                                       input logic [DEST_W-1:0] ldest,
                                       input logic [MODEL_W-1:0] model);
    if (model == MODEL_FLAT)         return flat_hit(dest, ldest);
    else if (model == MODEL_CLUSTER) return cluster_hit(dest, ldest);
    else                             return 1'b0;
  endfunction

  function automatic logic dmode_delivers(input logic [DM_W-1:0] dm);
    return dm != 3'd3;
  endfunction
endpackage

// File: rtl/msi_field_decode.sv
module msi_field_decode
  import irq_route_pkg::*;
(
  input  logic [19:0]       addr,
  input  logic [15:0]       data,
  output logic [DEST_W-1:0] dest,
  output logic              logical,
  output logic [DM_W-1:0]   dmode,
  output logic [7:0]        vector,
  output logic              trig
);
  assign dest    = addr[19:12];
  assign logical = addr[2];
  assign vector  = data[7:0];
  assign dmode   = data[10:8];
  assign trig    = data[15];

  logic spare_bits;
  assign spare_bits = ^{addr[11:3], addr[1:0], data[14:11]};
endmodule

// File: rtl/agent_matcher.sv
module agent_matcher
  import irq_route_pkg::*;
#(
  parameter int N_AGENTS = 8
) (
  input  logic [DEST_W-1:0]          dest,
  input  logic                       logical,
  input  logic [DEST_W*N_AGENTS-1:0]  ids,
  input  logic [DEST_W*N_AGENTS-1:0]  ldests,
  input  logic [MODEL_W*N_AGENTS-1:0] models,
  output logic [N_AGENTS-1:0]         phys_eq,
  output logic [N_AGENTS-1:0]         log_hit
);
  for (genvar k = 0; k < N_AGENTS; k++) begin : g_agent
    logic [DEST_W-1:0]  id_k;
    logic [DEST_W-1:0]  ld_k;
    logic [MODEL_W-1:0] md_k;
    assign id_k = ids[k*DEST_W +: DEST_W];
    assign ld_k = ldests[k*DEST_W +: DEST_W];
    assign md_k = models[k*MODEL_W +: MODEL_W];
    assign phys_eq[k] = !logical && (id_k == dest);
    assign log_hit[k] = logical && logical_hit(dest, ld_k, md_k);
  end
endmodule

// File: rtl/lowest_pick.sv
module lowest_pick #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] raw,
  output logic [WIDTH-1:0] pick
);
  assign pick = raw & (~raw + 1'b1);
endmodule

// File: rtl/irq_dest_resolver.sv
module irq_dest_resolver
  import irq_route_pkg::*;
#(
  parameter int N_AGENTS = 8,
  localparam int IDX_W = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  input  logic                        req_is_msi,
  input  logic [7:0]                  cmd_dest,
  input  logic                        cmd_logical,
  input  logic [1:0]                  cmd_shorthand,
  input  logic [2:0]                  cmd_dmode,
  input  logic [7:0]                  cmd_vector,
  input  logic                        cmd_trig,
  input  logic                        cmd_level,
  input  logic [IDX_W-1:0]            self_idx,
  input  logic [19:0]                 msi_addr,
  input  logic [15:0]                 msi_data,
  input  logic [8*N_AGENTS-1:0]       agent_id,
  input  logic [8*N_AGENTS-1:0]       agent_ldest,
  input  logic [4*N_AGENTS-1:0]       agent_model,
  output logic                        out_valid,
  output logic [N_AGENTS-1:0]         out_mask,
  output logic [N_AGENTS-1:0]         arb_load_mask,
  output logic [2:0]                  out_dmode,
  output logic [7:0]                  out_vector,
  output logic                        out_trig
);
  localparam logic [N_AGENTS-1:0] ALL_ONES = {N_AGENTS{1'b1}};

  logic [DEST_W-1:0] m_dest;
  logic              m_logical;
  logic [DM_W-1:0]   m_dmode;
  logic [7:0]        m_vector;
  logic              m_trig;

  msi_field_decode u_msi (
    .addr(msi_addr), .data(msi_data),
    .dest(m_dest), .logical(m_logical), .dmode(m_dmode),
    .vector(m_vector), .trig(m_trig)
  );

  logic [DEST_W-1:0] sel_dest;
  logic              sel_logical;
  logic [DM_W-1:0]   sel_dmode;
  logic [7:0]        sel_vector;
  logic              sel_trig;
  shorthand_e        sel_short;
  logic              is_deassert;

  always_comb begin
    if (req_is_msi) begin
      sel_dest    = m_dest;
      sel_logical = m_logical;
      sel_dmode   = m_dmode;
      sel_vector  = m_vector;
      sel_trig    = m_trig;
      sel_short   = SH_NONE;
    end else begin
      sel_dest    = cmd_dest;
      sel_logical = cmd_logical;
      sel_dmode   = cmd_dmode;
      sel_vector  = cmd_vector;
      sel_trig    = cmd_trig;
      sel_short   = shorthand_e'(cmd_shorthand);
    end
  end

  assign is_deassert = !req_is_msi && (cmd_dmode == DM_INIT) &&
                       !cmd_level && cmd_trig;

  logic [N_AGENTS-1:0] phys_eq, log_hit, phys_one;

  agent_matcher #(.N_AGENTS(N_AGENTS)) u_match (
    .dest(sel_dest), .logical(sel_logical),
    .ids(agent_id), .ldests(agent_ldest), .models(agent_model),
    .phys_eq(phys_eq), .log_hit(log_hit)
  );

  lowest_pick #(.WIDTH(N_AGENTS)) u_phys_pick (.raw(phys_eq), .pick(phys_one));

  logic [N_AGENTS-1:0] dest_set, self_bit, short_set, prio_one, target_set;

  always_comb begin
    if (sel_logical)                dest_set = log_hit;
    else if (sel_dest == DEST_ALL)  dest_set = ALL_ONES;
    else                            dest_set = phys_one;
  end

  always_comb begin
    self_bit = '0;
    self_bit[self_idx] = 1'b1;
  end

  always_comb begin
    unique case (sel_short)
      SH_SELF:   short_set = self_bit;
      SH_ALL:    short_set = ALL_ONES;
      SH_OTHERS: short_set = ALL_ONES & ~self_bit;
      default:   short_set = dest_set;
    endcase
  end

  lowest_pick #(.WIDTH(N_AGENTS)) u_prio_pick (.raw(short_set), .pick(prio_one));

  always_comb begin
    if (!dmode_delivers(sel_dmode))    target_set = '0;
    else if (sel_dmode == DM_LOWPRI)   target_set = prio_one;
    else                               target_set = short_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_mask      <= '0;
      arb_load_mask <= '0;
      out_dmode     <= '0;
      out_vector    <= '0;
      out_trig      <= 1'b0;
    end else begin
      out_valid <= req_valid;
      if (req_valid) begin
        out_mask      <= is_deassert ? '0 : target_set;
        arb_load_mask <= is_deassert ? target_set : '0;
        out_dmode     <= sel_dmode;
        out_vector    <= sel_vector;
        out_trig      <= sel_trig;
      end
    end
  end

  AST_PICK_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(prio_one) && ((prio_one & ~short_set) == '0));           // R6
  AST_LOWPRI_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_dmode == DM_LOWPRI) |-> $onehot0(out_mask));     // R6
  AST_UNDEF_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_dmode == 3'd3) |-> (out_mask == '0));            // R7
  AST_DEASSERT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_load_mask != '0) |-> (out_mask == '0 && out_dmode == DM_INIT)); // R8
  AST_PHYS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(phys_one));                                                // R2
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid);                                           // R10
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!out_valid && $stable(out_mask) && $stable(arb_load_mask))); // R10
endmodule

// File: tb/irq_dest_resolver_test.sv
module irq_dest_resolver_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic clk = 0;
  logic rst_n = 0;
  logic req_valid = 0, req_is_msi = 0;
  logic [7:0] cmd_dest = 0;
  logic cmd_logical = 0;
  logic [1:0] cmd_shorthand = 0;
  logic [2:0] cmd_dmode = 0;
  logic [7:0] cmd_vector = 0;
  logic cmd_trig = 0, cmd_level = 1;
  logic [2:0] self_idx = 0;
  logic [19:0] msi_addr = 0;
  logic [15:0] msi_data = 0;
  logic [8*N-1:0] agent_id, agent_ldest;
  logic [4*N-1:0] agent_model;
  logic out_valid;
  logic [N-1:0] out_mask, arb_load_mask;
  logic [2:0] out_dmode;
  logic [7:0] out_vector;
  logic out_trig;

  int n_tests = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_dest_resolver #(.N_AGENTS(N)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_msi(req_is_msi),
    .cmd_dest(cmd_dest), .cmd_logical(cmd_logical), .cmd_shorthand(cmd_shorthand),
    .cmd_dmode(cmd_dmode), .cmd_vector(cmd_vector), .cmd_trig(cmd_trig),
    .cmd_level(cmd_level), .self_idx(self_idx), .msi_addr(msi_addr),
    .msi_data(msi_data), .agent_id(agent_id), .agent_ldest(agent_ldest),
    .agent_model(agent_model), .out_valid(out_valid), .out_mask(out_mask),
    .arb_load_mask(arb_load_mask), .out_dmode(out_dmode), .out_vector(out_vector),
    .out_trig(out_trig)
  );

  // Agents: IDs 0x10+k, except agent 5 shares ID 0x12 with agent 2.
  // Agents 0..2 flat with logical bytes 1,2,4; agent 3 model 0x7, byte 0x08.
  // Agents 4..7 cluster with bytes 0x31,0x32,0x41,0x43.
  initial begin
    for (int k = 0; k < N; k++) agent_id[k*8 +: 8] = 8'h10 + 8'(k);
    agent_id[5*8 +: 8] = 8'h12;
    agent_ldest = {8'h43, 8'h41, 8'h32, 8'h31, 8'h08, 8'h04, 8'h02, 8'h01};
    agent_model = {4'h0, 4'h0, 4'h0, 4'h0, 4'h7, 4'hF, 4'hF, 4'hF};
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cmd(input logic [7:0] d, input logic lg, input logic [1:0] sh,
                     input logic [2:0] dm, input logic tr, input logic lv,
                     input logic [2:0] self);
    @(negedge clk);
    req_is_msi = 0; cmd_dest = d; cmd_logical = lg; cmd_shorthand = sh;
    cmd_dmode = dm; cmd_trig = tr; cmd_level = lv; self_idx = self;
    cmd_vector = d ^ 8'h5C;
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic msi(input logic [19:0] a, input logic [15:0] d, input logic [1:0] sh);
    @(negedge clk);
    req_is_msi = 1; msi_addr = a; msi_data = d; cmd_shorthand = sh;
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic t_reset;
    chk("R10 reset valid", 32'(out_valid), 0);
    chk("R10 reset mask", 32'(out_mask), 0);
    chk("R10 reset arb", 32'(arb_load_mask), 0);
  endtask

  task automatic t_physical;
    cmd(8'hFF, 0, 0, 0, 0, 1, 0); chk("R1 broadcast", 32'(out_mask), 32'hFF);
    chk("R10 valid after req", 32'(out_valid), 1);
    chk("R7 vector passed", 32'(out_vector), 32'(8'hFF ^ 8'h5C));
    cmd(8'h13, 0, 0, 0, 0, 1, 0); chk("R2 id match", 32'(out_mask), 32'h08);
    cmd(8'h12, 0, 0, 0, 0, 1, 0); chk("R2 duplicate id lowest", 32'(out_mask), 32'h04);
    cmd(8'h77, 0, 0, 0, 0, 1, 0); chk("R2 no match", 32'(out_mask), 32'h00);
  endtask

  task automatic t_logical;
    cmd(8'h05, 1, 0, 0, 0, 1, 0); chk("R3 flat", 32'(out_mask), 32'h05);
    cmd(8'h31, 1, 0, 0, 0, 1, 0); chk("R4 cluster plus flat", 32'(out_mask), 32'h11);
    cmd(8'h43, 1, 0, 0, 0, 1, 0); chk("R4 cluster two", 32'(out_mask), 32'hC3);
    cmd(8'h08, 1, 0, 0, 0, 1, 0); chk("R4 odd model excluded", 32'(out_mask), 32'h00);
  endtask

  task automatic t_shorthand;
    cmd(8'h13, 0, 1, 0, 0, 1, 6); chk("R5 self", 32'(out_mask), 32'h40);
    cmd(8'h13, 0, 2, 0, 0, 1, 6); chk("R5 all", 32'(out_mask), 32'hFF);
    cmd(8'h13, 1, 3, 0, 0, 1, 6); chk("R5 others", 32'(out_mask), 32'hBF);
  endtask

  task automatic t_modes;
    cmd(8'h43, 1, 0, 1, 0, 1, 0); chk("R6 lowpri logical", 32'(out_mask), 32'h01);
    cmd(8'h00, 0, 3, 1, 0, 1, 0); chk("R6 lowpri others", 32'(out_mask), 32'h02);
    cmd(8'hFF, 0, 0, 3, 0, 1, 0); chk("R7 mode3 empty", 32'(out_mask), 32'h00);
    chk("R7 mode3 dmode out", 32'(out_dmode), 3);
    cmd(8'hFF, 0, 0, 2, 0, 1, 0); chk("R7 mode2 passes", 32'(out_mask), 32'hFF);
    cmd(8'h43, 1, 0, 7, 1, 1, 0); chk("R7 mode7 passes", 32'(out_mask), 32'hC3);
    chk("R7 trig passed", 32'(out_trig), 1);
  endtask

  task automatic t_deassert;
    cmd(8'hFF, 0, 0, 5, 1, 0, 0);
    chk("R8 deassert mask", 32'(out_mask), 32'h00);
    chk("R8 deassert arb", 32'(arb_load_mask), 32'hFF);
    cmd(8'h13, 0, 0, 5, 1, 1, 0);
    chk("R8 assert init mask", 32'(out_mask), 32'h08);
    chk("R8 assert init arb", 32'(arb_load_mask), 32'h00);
  endtask

  task automatic t_msi;
    msi({8'h13, 12'h000}, {1'b1, 4'h0, 3'd4, 8'h5A}, 2'd2);
    chk("R9 msi phys mask", 32'(out_mask), 32'h08);
    chk("R9 msi dmode", 32'(out_dmode), 4);
    chk("R9 msi vector", 32'(out_vector), 32'h5A);
    chk("R9 msi trig", 32'(out_trig), 1);
    msi({8'h43, 12'h004}, {1'b0, 4'h0, 3'd0, 8'h21}, 2'd1);
    chk("R9 msi logical", 32'(out_mask), 32'hC3);
    msi({8'hFF, 12'h000}, {1'b1, 4'h0, 3'd5, 8'h00}, 2'd0);
    chk("R9 msi init delivers", 32'(out_mask), 32'hFF);
    chk("R9 msi no arb", 32'(arb_load_mask), 32'h00);
  endtask

  task automatic t_hold;
    cmd(8'h13, 0, 0, 0, 0, 1, 0);
    @(negedge clk);
    chk("R10 valid drops", 32'(out_valid), 0);
    chk("R10 mask held", 32'(out_mask), 32'h08);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_physical;
    t_logical;
    t_shorthand;
    t_modes;
    t_deassert;
    t_msi;
    t_hold;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule